// File: doc/BRIEF.md
# Entropy Sampling Front End

This block sits between a free-running entropy source and the rest of a random-number subsystem. The source delivers one raw bit per handshake on a valid/ready input stream. The block thins that stream with a selectable prescaler and discards a programmable number of leading prescaled bits so the source can settle. It then takes a fixed number of sample bits. Each sample bit can pass through a Von Neumann corrector. A route-mode input picks, independently for each consumer, whether the entropy accumulator and the statistics output see corrected or raw bits.

When the sample count is reached, the 32-bit accumulated word is presented with `ent_valid` high and the source is held off. Outside that window the word reads as zero. Reading the word with `ent_read`, or pulsing `restart` at any time, clears the accumulator and every counter and begins a new run. Back-pressure rule: `src_ready` is high while a run is in progress. It is low while the result is held and in any cycle that `restart` is high. A bit counts as transferred only when `src_valid` and `src_ready` are both high. The statistics output is a valid-only stream with no ready; its consumer must accept a bit in every cycle that `stat_valid` is high.

Top module: `entropy_front_end`

## Requirements
- R1: With `route_mode` = 0, both the accumulator and the statistics output receive corrected bits.
- R2: With `route_mode` = 1, both the accumulator and the statistics output receive every accepted raw bit.
- R3: With `route_mode` = 2, the accumulator receives corrected bits and the statistics output receives raw bits.
- R4: `route_mode` = 3 behaves exactly like `route_mode` = 0.
- R5: With `div_sel` = d, only transfers number 2^d, 2·2^d, 3·2^d, … since the run start are kept. A kept transfer is a prescaled strobe. All other transfers are dropped.
- R6: The first `delay_cfg` prescaled strobes of a run are discarded. Every later prescaled strobe is an accepted sample bit.
- R7: `ent_valid` rises one cycle after the transfer that brings the accepted-bit count to `size_cfg`. A value of 0 acts as 1. Once high, `ent_valid` and `ent_data` hold until `ent_read` or `restart`.
- R8: `ent_data` is 0 whenever `ent_valid` is low. When valid, it holds the routed accumulator bits, newest in bit 0 and shifted left.
- R9: `restart` always clears `ent_valid`, the accumulator and all counters. `ent_read` does the same when `ent_valid` is high, and has no effect while busy.
- R10: `src_ready` = 0 while `ent_valid` is high or `restart` is high, and 1 otherwise after reset.
- R11: The corrector groups accepted bits into non-overlapping pairs, first bit then second. It emits 0 for the pair (0,1) and 1 for the pair (1,0), and emits nothing for equal pairs.
- R12: `stat_valid` is high for exactly the cycle after each transfer whose bit is routed to the statistics output. `stat_bit` carries that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_valid | input | 1 | Raw source bit offered |
| src_ready | output | 1 | Block can take a source bit |
| src_bit | input | 1 | Raw source bit |
| route_mode | input | 2 | Routing of corrected/raw bits (0..3) |
| div_sel | input | 2 | Prescale select: divide by 1, 2, 4, 8 |
| delay_cfg | input | 16 | Prescaled strobes discarded at run start |
| size_cfg | input | 16 | Accepted sample bits per run |
| restart | input | 1 | Pulse: abandon run and start anew |
| ent_read | input | 1 | Pulse: consume held word and start anew |
| ent_valid | output | 1 | Run complete, word valid |
| ent_data | output | 32 | Accumulated entropy word, zero while busy |
| stat_valid | output | 1 | Statistics bit present |
| stat_bit | output | 1 | Bit for the statistics path |

## Verification
Two events can land together. A `restart` can arrive in the same cycle as a source transfer that would have been the final sample. An `ent_read` can arrive in a cycle where it is meaningless because the run is still busy. The bench drives random `ent_read` pulses and occasional mid-run restarts with source activity present in the same cycles. It expects the restart to win: `src_ready` drops, so the bit is not taken. It expects a busy-time read to leave the run, the ready signal and the statistics stream untouched. Each cycle, every output is compared with an arithmetic model of the requirements.

// File: rtl/efe_pkg.sv
package efe_pkg;
  typedef enum logic [1:0] {
    RT_VN_BOTH   = 2'd0,
    RT_RAW_BOTH  = 2'd1,
    RT_SPLIT     = 2'd2,
    RT_RESERVED  = 2'd3
  } route_e;

  // returns {accumulator_takes_raw, statistics_takes_raw}
  function automatic logic [1:0] route_raw(route_e m);
    case (m)
      RT_RAW_BOTH: return 2'b11;
      RT_SPLIT:    return 2'b01;
      default:     return 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/efe_prescaler.sv
module efe_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel,
  output logic             pass
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   full_mask;
  logic [CNT_W-1:0] mask;

  always_comb begin
    full_mask = ((CNT_W+1)'(1) << sel) - (CNT_W+1)'(1);
    mask      = full_mask[CNT_W-1:0];
    pass      = tick && ((cnt & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (tick)  cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/efe_run_ctrl.sv
module efe_run_ctrl #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          pass,
  input  logic [CW-1:0] delay,
  input  logic [CW-1:0] size,
  output logic          accept,
  output logic          done
);
  logic [CW-1:0] dcnt;
  logic [CW-1:0] scnt;
  logic [CW:0]   scnt_nxt;
  logic          settled;

  always_comb begin
    settled  = (dcnt >= delay);
    accept   = pass && !done && settled;
    scnt_nxt = {1'b0, scnt} + (CW+1)'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt <= '0;
      scnt <= '0;
      done <= 1'b0;
    end else if (clr) begin
      dcnt <= '0;
      scnt <= '0;
      done <= 1'b0;
    end else if (pass && !done) begin
      if (!settled) begin
        dcnt <= dcnt + CW'(1);
      end else begin
        scnt <= scnt_nxt[CW-1:0];
        if (scnt_nxt >= {1'b0, size}) done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/efe_vn_corrector.sv
module efe_vn_corrector (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic in_vld,
  input  logic in_bit,
  output logic out_vld,
  output logic out_bit
);
  logic have_first;
  logic first_bit;

  always_comb begin
    out_vld = in_vld && have_first && (first_bit != in_bit);
    out_bit = first_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_first <= 1'b0;
      first_bit  <= 1'b0;
    end else if (clr) begin
      have_first <= 1'b0;
      first_bit  <= 1'b0;
    end else if (in_vld) begin
      have_first <= !have_first;
      if (!have_first) first_bit <= in_bit;
    end
  end
endmodule

// File: rtl/entropy_front_end.sv
module entropy_front_end #(
  parameter int ENT_W = 32,
  parameter int CW    = 16,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_valid,
  output logic             src_ready,
  input  logic             src_bit,
  input  logic [1:0]       route_mode,
  input  logic [SEL_W-1:0] div_sel,
  input  logic [CW-1:0]    delay_cfg,
  input  logic [CW-1:0]    size_cfg,
  input  logic             restart,
  input  logic             ent_read,
  output logic             ent_valid,
  output logic [ENT_W-1:0] ent_data,
  output logic             stat_valid,
  output logic             stat_bit
);
  import efe_pkg::*;

  logic             done;
  logic             xfer;
  logic             clr;
  logic             pass;
  logic             accept;
  logic             vn_vld;
  logic             vn_bit;
  logic [1:0]       raw_sel;
  logic             acc_emit;
  logic             acc_bit;
  logic             st_emit;
  logic             st_bit_n;
  logic [ENT_W-1:0] shreg;

  always_comb begin
    src_ready = !done && !restart;
    xfer      = src_valid && src_ready;
    clr       = restart || (ent_read && done);
    raw_sel   = route_raw(route_e'(route_mode));
    acc_emit  = raw_sel[1] ? accept : vn_vld;
    acc_bit   = raw_sel[1] ? src_bit : vn_bit;
    st_emit   = raw_sel[0] ? accept : vn_vld;
    st_bit_n  = raw_sel[0] ? src_bit : vn_bit;
    ent_valid = done;
    ent_data  = done ? shreg : '0;
  end

  efe_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(xfer), .sel(div_sel), .pass(pass)
  );

  efe_run_ctrl #(.CW(CW)) u_run (
    .clk(clk), .rst_n(rst_n), .clr(clr), .pass(pass),
    .delay(delay_cfg), .size(size_cfg), .accept(accept), .done(done)
  );

  efe_vn_corrector u_vn (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(accept), .in_bit(src_bit),
    .out_vld(vn_vld), .out_bit(vn_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      stat_valid <= 1'b0;
      stat_bit   <= 1'b0;
    end else if (clr) begin
      shreg      <= '0;
      stat_valid <= 1'b0;
      stat_bit   <= 1'b0;
    end else begin
      if (acc_emit) shreg <= {shreg[ENT_W-2:0], acc_bit};
      stat_valid <= st_emit;
      if (st_emit) stat_bit <= st_bit_n;
    end
  end
endmodule

// File: rtl/efe_checker.sv
module efe_checker #(
  parameter int ENT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             src_valid,
  input logic             src_ready,
  input logic             restart,
  input logic             ent_read,
  input logic             ent_valid,
  input logic [ENT_W-1:0] ent_data,
  input logic             stat_valid
);
  assert_ready_low_when_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid || restart) |-> !src_ready);

  assert_word_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && !ent_read && !restart) |=> (ent_valid && $stable(ent_data)));

  assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!ent_valid && !stat_valid));

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_read && ent_valid) |=> !ent_valid);

  assert_stat_after_transfer_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> $past(src_valid && src_ready));
endmodule

bind entropy_front_end efe_checker #(.ENT_W(ENT_W)) u_efe_checker (
  .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ready(src_ready),
  .restart(restart), .ent_read(ent_read), .ent_valid(ent_valid),
  .ent_data(ent_data), .stat_valid(stat_valid)
);

// File: tb/test_entropy_front_end.sv
`timescale 1ns/1ps
module test_entropy_front_end;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_valid = 1'b0;
  logic        src_ready;
  logic        src_bit = 1'b0;
  logic [1:0]  route_mode = 2'd0;
  logic [1:0]  div_sel = 2'd0;
  logic [15:0] delay_cfg = 16'd0;
  logic [15:0] size_cfg = 16'd1;
  logic        restart = 1'b0;
  logic        ent_read = 1'b0;
  logic        ent_valid;
  logic [31:0] ent_data;
  logic        stat_valid;
  logic        stat_bit;

  always #2.5 clk = ~clk;

  entropy_front_end i_entropy_front_end (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ready(src_ready),
    .src_bit(src_bit), .route_mode(route_mode), .div_sel(div_sel),
    .delay_cfg(delay_cfg), .size_cfg(size_cfg), .restart(restart),
    .ent_read(ent_read), .ent_valid(ent_valid), .ent_data(ent_data),
    .stat_valid(stat_valid), .stat_bit(stat_bit)
  );

  int vectors = 0;
  int fails = 0;
  logic [31:0] lfsr = 32'hACE1_2468;

  // behavioural model state
  logic        m_done, m_have, m_held, e_sv, e_sb;
  int          m_pc, m_dcnt, m_scnt;
  logic [31:0] m_sh;

  function automatic string route_tag(logic [1:0] m);
    case (m)
      2'd0: return "R1/R11";
      2'd1: return "R2";
      2'd2: return "R3/R11";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h mode=%0d div=%0d dly=%0d size=%0d",
               tag, act, exp, route_mode, div_sel, delay_cfg, size_cfg);
    end
  endtask

  task automatic model_clear();
    m_done = 0; m_have = 0; m_held = 0; m_pc = 0; m_dcnt = 0; m_scnt = 0;
    m_sh = '0; e_sv = 0; e_sb = 0;
  endtask

  function automatic logic [31:0] rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  task automatic cycle(logic v, logic b, logic rd, logic rs);
    logic vn_v, vn_b, a_raw, s_raw, pass;
    int period;
    @(negedge clk);
    // per-cycle comparison; model covers R5 prescale, R6 delay, R11 pairing
    chk({route_tag(route_mode), "/R12 stat_valid"}, 32'(stat_valid), 32'(e_sv));
    if (e_sv) chk({route_tag(route_mode), " stat_bit"}, 32'(stat_bit), 32'(e_sb));
    chk("R7 ent_valid (R5/R6 timing)", 32'(ent_valid), 32'(m_done));
    chk(m_done ? "R8/R9 ent_data" : "R8 ent_data busy", ent_data, m_done ? m_sh : 32'd0);
    chk("R10 src_ready", 32'(src_ready), 32'(!m_done && !restart));
    src_valid = v; src_bit = b; ent_read = rd; restart = rs;
    e_sv = 0;
    if (rs || (rd && m_done)) begin
      model_clear();
    end else if (v && !m_done) begin
      period = 1 << div_sel;
      pass = ((m_pc % period) == period - 1);
      m_pc++;
      if (pass) begin
        if (m_dcnt < int'(delay_cfg)) m_dcnt++;
        else begin
          vn_v = 0; vn_b = 0;
          if (m_have) begin
            m_have = 0;
            if (m_held != b) begin vn_v = 1; vn_b = m_held; end
          end else begin
            m_have = 1; m_held = b;
          end
          a_raw = (route_mode == 2'd1);
          s_raw = (route_mode == 2'd1) || (route_mode == 2'd2);
          if (a_raw) m_sh = {m_sh[30:0], b};
          else if (vn_v) m_sh = {m_sh[30:0], vn_b};
          e_sv = s_raw ? 1'b1 : vn_v;
          e_sb = s_raw ? b : vn_b;
          m_scnt++;
          if (m_scnt >= int'(size_cfg)) m_done = 1;
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int idx;
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // reset state
    chk("R8 reset ent_data", ent_data, 32'd0);
    chk("R7 reset ent_valid", 32'(ent_valid), 32'd0);
    chk("R10 reset src_ready", 32'(src_ready), 32'd1);
    chk("R12 reset stat_valid", 32'(stat_valid), 32'd0);
    idx = 0;
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 4; d++) begin
        for (int dl = 0; dl < 2; dl++) begin
          for (int sz = 0; sz < 3; sz++) begin
            int n;
            logic [31:0] r;
            route_mode = 2'(m);
            div_sel = 2'(d);
            delay_cfg = (dl == 0) ? 16'd0 : 16'd3;
            size_cfg = (sz == 0) ? 16'd1 : (sz == 1) ? 16'd7 : 16'd40;
            cycle(1'b1, 1'b1, 1'b0, 1'b1); // R9: restart with source active
            n = 0;
            while (!m_done && n < 5000) begin
              r = rnd();
              cycle(r[0] | r[1], r[2], (r[7:4] == 4'd0), (idx % 5 == 0) && (n == 6));
              n++;
            end
            cycle(1'b1, 1'b0, 1'b0, 1'b0); // R10: offered bit held off
            cycle(1'b0, 1'b0, 1'b0, 1'b0); // R7 hold
            if (idx % 2 == 0) cycle(1'b1, 1'b1, 1'b1, 1'b0); // R9 read ends run
            else cycle(1'b1, 1'b1, 1'b0, 1'b1);              // R9 restart ends run
            cycle(1'b0, 1'b0, 1'b0, 1'b0);
            idx++;
          end
        end
      end
    end
    cycle(1'b0, 1'b0, 1'b0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule